// File: doc/BRIEF.md
# Self-Test Observation Register

This block is a register bank of parameterizable width that serves both normal operation and built-in self-test. Three control inputs select its behaviour on each rising clock edge. It can capture parallel data like an ordinary D register. It can clear itself. It can act as a scan chain filled from one serial wire. It can run as a linear feedback shift register that produces pseudorandom patterns. It can also compress parallel data into a signature, as a multiple-input signature register.

In a self-test setup, one instance drives stimulus into the logic under test. A second instance, at that logic's outputs, compacts the responses. The seed of a pattern generator is loaded beforehand through the serial input. When compaction finishes, the signature leaves through the serial output, which always shows the last stage. A test controller, a comparison against a golden signature and the logic under test all sit outside this block.

Top module: `selftest_reg`

## Requirements
- R1: While `rst_n` is low, every stage of `q_out` is 0 and `scan_out` is 0, independent of the clock.
- R2: With `sel_par`=1 and `sel_norm`=1, `q_out` takes the value of `d_in` at the clock edge.
- R3: With `sel_par`=0 and `sel_norm`=1, `q_out` becomes all zeros at the clock edge, whatever `d_in` holds.
- R4: With `sel_par`=0, `sel_norm`=0 and `sel_ext`=1, the register shifts toward the high index. Bit 0 takes `scan_in` and bit i takes the old bit i-1. `d_in` has no effect.
- R5: With `sel_par`=0, `sel_norm`=0 and `sel_ext`=0, the register shifts toward the high index. Bit 0 takes the XOR of the old stages selected by the set bits of `TAPS`. The default `TAPS` is 4'b1100, so the new bit 0 is q[3]^q[2]. `d_in` has no effect.
- R6: With the default 4-bit configuration in pattern mode, any nonzero seed passes through all 15 nonzero states. It returns to itself after exactly 15 edges.
- R7: In pattern mode, the all-zero state stays all-zero when clocked.
- R8: With `sel_par`=1, `sel_norm`=0 and `sel_ext`=0, bit i (i>0) takes `d_in[i]` XOR the old bit i-1. Bit 0 takes `d_in[0]` XOR the feedback value defined in R5.
- R9: With `sel_par`=1, `sel_norm`=0 and `sel_ext`=1, the behaviour is that of R8, except that bit 0 takes `d_in[0]` XOR `scan_in`.
- R10: `scan_out` always equals the most significant stage of `q_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sel_par | input | 1 | Control: parallel data path enable |
| sel_norm | input | 1 | Control: normal (non-shifting) operation |
| sel_ext | input | 1 | Control: first stage fed from `scan_in` instead of feedback |
| d_in | input | W | Parallel data input |
| scan_in | input | 1 | Serial input to the first stage |
| q_out | output | W | Parallel register contents |
| scan_out | output | 1 | Serial output, the last stage |

## Verification
All state is visible on `q_out`, so a single wrong stage or a bad control decode shows on the edge right after the faulty cycle. A wrong feedback tap is different. It can produce a correct-looking next state for some seeds, so the bench walks every nonzero seed through a full 15-step cycle. A tap error then either breaks the step-by-step match or shortens the period. A wrong XOR in signature mode corrupts the stage it feeds at once, and that error propagates one stage further on each later edge until it reaches `scan_out`.

// File: rtl/selftest_pkg.sv
package selftest_pkg;
  typedef enum logic [2:0] {
    OP_CLEAR    = 3'd0,
    OP_LOAD     = 3'd1,
    OP_SCAN     = 3'd2,
    OP_PRPG     = 3'd3,
    OP_SIG      = 3'd4,
    OP_SIG_EXT  = 3'd5
  } op_e;

  // Stage 0 input comes from the serial pin in these operations.
  function automatic logic head_from_pin(op_e op);
    return (op == OP_SCAN) || (op == OP_SIG_EXT);
  endfunction
endpackage

// File: rtl/selftest_decode.sv
module selftest_decode
  import selftest_pkg::*;
(
  input  logic sel_par,
  input  logic sel_norm,
  input  logic sel_ext,
  output op_e  op
);
  always_comb begin
    if (sel_norm) begin
      op = sel_par ? OP_LOAD : OP_CLEAR;
    end else if (!sel_par) begin
      op = sel_ext ? OP_SCAN : OP_PRPG;
    end else begin
      op = sel_ext ? OP_SIG_EXT : OP_SIG;
    end
  end
endmodule

// File: rtl/selftest_fb.sv
module selftest_fb #(
  parameter int unsigned   W    = 4,
  parameter logic [W-1:0]  TAPS = 4'b1100
) (
  input  logic [W-1:0] q,
  output logic         fb
);
  // Fibonacci feedback: parity of the tapped stages.
  always_comb begin
    fb = ^(q & TAPS);
  end
endmodule

// File: rtl/selftest_stage.sv
module selftest_stage
  import selftest_pkg::*;
(
  input  op_e  op,
  input  logic d_bit,
  input  logic chain_bit,
  output logic nxt_bit
);
  always_comb begin
    unique case (op)
      OP_LOAD:              nxt_bit = d_bit;
      OP_CLEAR:             nxt_bit = 1'b0;
      OP_SCAN, OP_PRPG:     nxt_bit = chain_bit;
      OP_SIG, OP_SIG_EXT:   nxt_bit = d_bit ^ chain_bit;
      default:              nxt_bit = 1'b0;
    endcase
  end
endmodule

// File: rtl/selftest_reg.sv
module selftest_reg
  import selftest_pkg::*;
#(
  parameter int unsigned   W    = 4,
  parameter logic [W-1:0]  TAPS = 4'b1100
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel_par,
  input  logic         sel_norm,
  input  logic         sel_ext,
  input  logic [W-1:0] d_in,
  input  logic         scan_in,
  output logic [W-1:0] q_out,
  output logic         scan_out
);
  localparam int unsigned MSB = W - 1;

  op_e          op;
  logic         fb;
  logic         head;
  logic [W-1:0] chain;
  logic [W-1:0] q_nxt;
  logic [W-1:0] q_r;

  selftest_decode u_dec (
    .sel_par  (sel_par),
    .sel_norm (sel_norm),
    .sel_ext  (sel_ext),
    .op       (op)
  );

  selftest_fb #(.W(W), .TAPS(TAPS)) u_fb (
    .q  (q_r),
    .fb (fb)
  );

  always_comb begin
    head = head_from_pin(op) ? scan_in : fb;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == 0) begin : g_head
      always_comb chain[i] = head;
    end else begin : g_link
      always_comb chain[i] = q_r[i-1];
    end

    selftest_stage u_stage (
      .op        (op),
      .d_bit     (d_in[i]),
      .chain_bit (chain[i]),
      .nxt_bit   (q_nxt[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
    end else begin
      q_r <= q_nxt;
    end
  end

  assign q_out    = q_r;
  assign scan_out = q_r[MSB];
endmodule

// File: rtl/selftest_reg_chk.sv
module selftest_reg_chk #(
  parameter int unsigned   W    = 4,
  parameter logic [W-1:0]  TAPS = 4'b1100
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sel_par,
  input logic         sel_norm,
  input logic         sel_ext,
  input logic [W-1:0] d_in,
  input logic         scan_in,
  input logic [W-1:0] q_out,
  input logic         scan_out
);
  logic m_load, m_clear, m_scan, m_prpg, m_sig, m_sig_ext;
  assign m_load    =  sel_par &  sel_norm;
  assign m_clear   = !sel_par &  sel_norm;
  assign m_scan    = !sel_par & !sel_norm &  sel_ext;
  assign m_prpg    = !sel_par & !sel_norm & !sel_ext;
  assign m_sig     =  sel_par & !sel_norm & !sel_ext;
  assign m_sig_ext =  sel_par & !sel_norm &  sel_ext;

  p_reset_zero_r1: assert property (@(posedge clk) !rst_n |-> (q_out == '0));

  p_par_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    m_load |=> (q_out == $past(d_in)));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    m_clear |=> (q_out == '0));

  p_scan_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    m_scan |=> (q_out == {$past(q_out[W-2:0]), $past(scan_in)}));

  p_prpg_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    m_prpg |=> (q_out == {$past(q_out[W-2:0]), ^($past(q_out) & TAPS)}));

  p_lockup_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_prpg && q_out == '0) |=> (q_out == '0));

  p_sig_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    m_sig |=> (q_out == ({$past(q_out[W-2:0]), ^($past(q_out) & TAPS)} ^ $past(d_in))));

  p_sig_ext_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    m_sig_ext |=> (q_out == ({$past(q_out[W-2:0]), $past(scan_in)} ^ $past(d_in))));

  p_serial_tap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_out[W-1]) |-> $rose(scan_out));
endmodule

bind selftest_reg selftest_reg_chk #(.W(W), .TAPS(TAPS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sel_par  (sel_par),
  .sel_norm (sel_norm),
  .sel_ext  (sel_ext),
  .d_in     (d_in),
  .scan_in  (scan_in),
  .q_out    (q_out),
  .scan_out (scan_out)
);

// File: tb/selftest_reg_tb.sv
`timescale 1ns/1ps
module selftest_reg_tb;
  localparam int W = 4;

  logic         clk;
  logic         rst_n;
  logic         sel_par, sel_norm, sel_ext;
  logic [W-1:0] d_in;
  logic         scan_in;
  logic [W-1:0] q_out;
  logic         scan_out;

  int checks;
  int fails;
  bit done;

  selftest_reg #(.W(W), .TAPS(4'b1100)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel_par(sel_par), .sel_norm(sel_norm),
    .sel_ext(sel_ext), .d_in(d_in), .scan_in(scan_in),
    .q_out(q_out), .scan_out(scan_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
    // R10: the serial output mirrors the top stage on every sample
    checks++;
    if (scan_out !== q_out[W-1]) begin
      fails++;
      $display("FAIL R10: actual %b expected %b", scan_out, q_out[W-1]);
    end
  endtask

  // Drive at the falling edge, clock, then sample 2 ns after the rising edge.
  task automatic step(input logic a, input logic b, input logic s,
                      input logic [W-1:0] d, input logic si);
    @(negedge clk);
    sel_par = a; sel_norm = b; sel_ext = s; d_in = d; scan_in = si;
    @(posedge clk);
    #2;
  endtask

  task automatic load(input logic [W-1:0] v);
    step(1'b1, 1'b1, 1'b0, v, 1'b0);
  endtask

  function automatic logic [W-1:0] prpg_next(input logic [W-1:0] q);
    return {q[2:0], q[3] ^ q[2]};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    sel_par = 1'b1; sel_norm = 1'b1; sel_ext = 1'b0; d_in = '0; scan_in = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R1", q_out, '0);
    // Load a nonzero value, then assert reset away from the edge.
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    load(4'b1011);
    #1 rst_n = 1'b0;
    #1 check("R1", q_out, '0);
    @(negedge clk) rst_n = 1'b1;

    // R2: every parallel value
    for (int v = 0; v < 16; v++) begin
      load(v[W-1:0]);
      check("R2", q_out, v[W-1:0]);
    end

    // R3: clear from every state, with data driven
    for (int v = 1; v < 16; v++) begin
      load(v[W-1:0]);
      step(1'b0, 1'b1, 1'b0, 4'hF, 1'b1);
      check("R3", q_out, '0);
    end

    // R4: shift in every seed with inverted data driven on d_in
    for (int v = 0; v < 16; v++) begin
      logic [W-1:0] exp;
      load(4'b0110);
      exp = 4'b0110;
      for (int k = W - 1; k >= 0; k--) begin
        step(1'b0, 1'b0, 1'b1, ~v[W-1:0], v[k]);
        exp = {exp[2:0], v[k]};
        check("R4", q_out, exp);
      end
    end

    // R5/R6: full cycle from every nonzero seed
    for (int seed = 1; seed < 16; seed++) begin
      logic [15:0] seen;
      logic [W-1:0] exp;
      seen = '0;
      load(seed[W-1:0]);
      exp = seed[W-1:0];
      for (int k = 0; k < 15; k++) begin
        seen[q_out] = 1'b1;
        step(1'b0, 1'b0, 1'b0, 4'hF, 1'b1);
        exp = prpg_next(exp);
        check("R5", q_out, exp);
        if (k < 14) begin
          checks++;
          if (q_out == seed[W-1:0]) begin
            fails++;
            $display("FAIL R6: actual early return at step %0d expected period 15", k + 1);
          end
        end
      end
      check("R6", q_out, seed[W-1:0]);
      check("R6", {3'b0, seen == 16'hFFFE}, 4'b0001);
    end

    // R7: lock-up state holds
    load('0);
    for (int k = 0; k < 5; k++) begin
      step(1'b0, 1'b0, 1'b0, 4'hF, 1'b1);
      check("R7", q_out, '0);
    end

    // R8/R9: one compaction step from every state with every data word
    for (int st = 0; st < 16; st++) begin
      for (int dv = 0; dv < 16; dv++) begin
        logic [W-1:0] s4, d4;
        s4 = st[W-1:0]; d4 = dv[W-1:0];
        load(s4);
        step(1'b1, 1'b0, 1'b0, d4, 1'b1);
        check("R8", q_out, {s4[2:0], s4[3] ^ s4[2]} ^ d4);
        load(s4);
        step(1'b1, 1'b0, 1'b1, d4, dv[0] ^ st[1]);
        check("R9", q_out, {s4[2:0], dv[0] ^ st[1]} ^ d4);
      end
    end

    // R8: multi-step signature over a data stream, then scan it out
    begin
      logic [W-1:0] sig;
      load('0);
      sig = '0;
      for (int k = 0; k < 20; k++) begin
        logic [W-1:0] dw;
        dw = W'((k * 7 + 3) % 16);
        step(1'b1, 1'b0, 1'b0, dw, 1'b0);
        sig = {sig[2:0], sig[3] ^ sig[2]} ^ dw;
        check("R8", q_out, sig);
      end
      for (int k = W - 1; k >= 0; k--) begin
        checks++;
        if (scan_out !== sig[k]) begin
          fails++;
          $display("FAIL R10: actual %b expected %b", scan_out, sig[k]);
        end
        step(1'b0, 1'b0, 1'b1, '0, 1'b0);
      end
    end

    finish_run();
  end
endmodule